// File: doc/BRIEF.md
# Dual-Mode FIFO with Replay

This block is a single-clock, first-in first-out word store. It has a 18-bit data path by default. The depth is a power of two, set by an address-width parameter. The default is 1024 words, and an address width of 14 gives 16384 words.

A style bit is captured while the master reset is held, and it fixes how the read side behaves:

- **Standard style:** the status outputs act as an active-low empty indicator and an active-low full indicator. Every word leaves the store only when a read is requested.
- **Fall-through style:** the status outputs act as an active-low "data on output" indicator and an active-high-when-full "no room" indicator. The oldest word is presented on the output without a request.

Two resets are provided. Both take effect asynchronously and are released on the clock.

- **Master reset:** empties the store, zeroes the output word and captures the style bit.
- **Partial reset:** empties the store and zeroes the output word, but keeps the style that was captured before.

A replay command rewinds the read side to storage location zero. The words written since the last reset can then be read again. Replay runs in two stages: a fixed-length setup window, during which the read status shows "nothing available", followed by normal reading from the first location.

Top module: `fifo_dualmode`

## Requirements
- R1: While `mrst_n` is low the level of `style_i` is captured: 0 selects standard style (after reset `rd_stat_n`=0, `wr_stat_n`=1), 1 selects fall-through style (after reset `rd_stat_n`=1, `wr_stat_n`=0); in both cases `dout` is all zeroes after reset.
- R2: Pulling `prst_n` low zeroes `dout` without waiting for a clock edge and empties the store; the captured style is kept whatever `style_i` is, and the status outputs take the after-reset levels of that style.
- R3: In standard style a write (`wen_n`=0 while `wr_stat_n`=1) makes `rd_stat_n` 1 right after that clock edge; a read (`ren_n`=0 while `rd_stat_n`=1) puts the oldest stored word on `dout` at that edge; words come out in write order.
- R4: In standard style `wr_stat_n` falls to 0 once DEPTH words are held; a write attempted while it is 0 stores nothing, so exactly DEPTH words can be read back.
- R5: In standard style a read attempted while `rd_stat_n`=0 leaves `dout` and the status unchanged.
- R6: In fall-through style a word written into an empty store is on `dout` with `rd_stat_n`=0 after the third rising edge counted from the write edge, with `ren_n` held high; it stays there until a read (`ren_n`=0 while `rd_stat_n`=0) moves to the next word.
- R7: In fall-through style `wr_stat_n` rises to 1 once the storage array is full; with the two output-side registers the store then holds DEPTH+2 words, and further writes are dropped.
- R8: A replay starts on an edge where `rt_n`=0 with `ren_n`=1 and `wen_n`=1; for RT_SETUP cycles the read status shows "none" (0 in standard, 1 in fall-through) and no read or write is accepted; afterwards reads return, from location zero onward, every word written since the last reset (at most DEPTH).
- R9: In fall-through style, after the replay setup window the first stored word is on `dout` when `rd_stat_n` returns to 0, two edges after the window ends, without any read request.
- R10: `rt_n`=0 on an edge where `ren_n` or `wen_n` is low does not start a replay; that edge's read or write proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| style_i | input | 1 | Read-style select, captured during master reset |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Replay request, active low |
| dout | output | DATA_W | Output word register |
| rd_stat_n | output | 1 | Read status: empty (standard) or output-valid (fall-through), active low |
| wr_stat_n | output | 1 | Write status: full (standard, low=full) or input-ready (fall-through, high=full) |

## Verification
The store is exercised in both styles with the following patterns:

- Isolated single writes, which pin down the one-edge and three-edge visibility delays.
- Back-to-back bursts with reads and writes on the same edge, which separate correct ordering from pointer-slip errors.
- Fill-to-capacity followed by a drain, which distinguishes the DEPTH limit of standard style from the DEPTH+2 limit of fall-through style.
- Replay, issued after partial reads, which shows that the read side rewinds to location zero rather than to the oldest unread word.
- A replay request made while a read is active, which must not rewind.
- A partial reset with the style input flipped, which shows the style is held and not re-sampled.

// File: rtl/fifo_dualmode_pkg.sv
package fifo_dualmode_pkg;

    // Read-side behaviour, fixed while the master reset is held.
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_style_e;

endpackage

// File: rtl/fifo_rst_sync.sv
// Asynchronous assertion, release after STAGES rising edges.
module fifo_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
// Word array: one synchronous write port, one combinational read port.
module fifo_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_dualmode.sv
module fifo_dualmode
    import fifo_dualmode_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 10,
    parameter int RT_SETUP    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              style_i,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ren_n,
    input  logic              rt_n,
    output logic [DATA_W-1:0] dout,
    output logic              rd_stat_n,
    output logic              wr_stat_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;
    localparam int RTW   = (RT_SETUP > 1) ? $clog2(RT_SETUP) : 1;
    localparam logic [CW-1:0]  FULL_CNT = CW'(DEPTH);
    localparam logic [RTW-1:0] RT_LAST  = RTW'(RT_SETUP - 1);

    typedef struct packed {
        logic [CW-1:0]     wptr;   // writes since reset, one extra bit
        logic [ADDR_W-1:0] rptr;
        logic [CW-1:0]     count;  // words held in the array
        logic              busy;   // replay setup window
        logic [RTW-1:0]    rtcnt;
        logic              stg_v;  // fall-through staging register
        logic [DATA_W-1:0] stg_d;
        logic              out_v;  // fall-through output valid
        logic [DATA_W-1:0] dout;
    } st_t;

    // ---------------- reset synchronisation ----------------
    logic mrst_s_n;
    logic prst_s_n;
    logic core_rst_n;

    fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_mrst_sync (
        .clk    (clk),
        .arst_n (mrst_n),
        .rst_n_o(mrst_s_n)
    );

    fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_prst_sync (
        .clk    (clk),
        .arst_n (prst_n),
        .rst_n_o(prst_s_n)
    );

    assign core_rst_n = mrst_s_n & prst_s_n;

    // Style register: loads only while the master reset is in force.
    rd_style_e mode_q;

    always_ff @(posedge clk) begin
        if (!mrst_s_n) mode_q <= rd_style_e'(style_i);
    end

    // ---------------- storage ----------------
    st_t               q;
    st_t               n;
    logic [DATA_W-1:0] mem_rd;
    logic              wr_go;
    logic              rt_go;
    logic              pop_mem;
    logic              take_out;
    logic              stage_free;
    logic [CW-1:0]     rewind_cnt;

    assign wr_go = !wen_n && (q.count != FULL_CNT) && !q.busy;
    assign rt_go = !rt_n && ren_n && wen_n && !q.busy;
    assign rewind_cnt = (q.wptr > FULL_CNT) ? FULL_CNT : q.wptr;

    fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .we   (wr_go),
        .waddr(q.wptr[ADDR_W-1:0]),
        .wdata(din),
        .raddr(q.rptr),
        .rdata(mem_rd)
    );

    // ---------------- next state ----------------
    always_comb begin
        n          = q;
        pop_mem    = 1'b0;
        take_out   = 1'b0;
        stage_free = 1'b0;

        if (q.busy) begin
            if (q.rtcnt == '0) n.busy = 1'b0;
            else               n.rtcnt = q.rtcnt - RTW'(1);
        end else if (rt_go) begin
            n.busy  = 1'b1;
            n.rtcnt = RT_LAST;
            n.rptr  = '0;
            n.stg_v = 1'b0;
            n.out_v = 1'b0;
        end else if (mode_q == RD_STANDARD) begin
            if (!ren_n && (q.count != '0)) begin
                n.dout  = mem_rd;
                pop_mem = 1'b1;
            end
        end else begin
            take_out   = !q.out_v || !ren_n;
            stage_free = !q.stg_v || take_out;
            if (take_out) begin
                n.out_v = q.stg_v;
                if (q.stg_v) n.dout = q.stg_d;
            end
            if (stage_free) begin
                n.stg_v = (q.count != '0);
                if (q.count != '0) begin
                    n.stg_d = mem_rd;
                    pop_mem = 1'b1;
                end
            end
        end

        if (rt_go) begin
            n.count = rewind_cnt;
        end else begin
            n.count = q.count + CW'(wr_go) - CW'(pop_mem);
            n.rptr  = q.rptr + ADDR_W'(pop_mem);
        end
        n.wptr = q.wptr + CW'(wr_go);
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) q <= '0;
        else             q <= n;
    end

    // ---------------- outputs ----------------
    assign dout      = q.dout;
    assign rd_stat_n = (mode_q == RD_FALLTHRU) ? (q.busy | ~q.out_v)
                                               : (~q.busy & (q.count != '0));
    assign wr_stat_n = (mode_q == RD_FALLTHRU) ? (q.count == FULL_CNT)
                                               : (q.count != FULL_CNT);
endmodule

// File: rtl/fifo_dualmode_chk.sv
module fifo_dualmode_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fwft,
    input logic              busy,
    input logic              wen_n,
    input logic              ren_n,
    input logic              rt_n,
    input logic [DATA_W-1:0] dout,
    input logic              rd_stat_n,
    input logic              wr_stat_n
);
    // R3: an accepted standard-style write leaves the store non-empty
    assert_write_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !busy && !wen_n && wr_stat_n) |=> rd_stat_n);

    // R4: full stays full when writing without reading
    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !wr_stat_n && !wen_n && ren_n) |=> !wr_stat_n);

    // R5: a read against an empty standard store leaves the output alone
    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && !rd_stat_n) |=> $stable(dout));

    // R6: a presented fall-through word holds until it is read
    assert_fwft_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && !rd_stat_n && ren_n && rt_n) |=> (!rd_stat_n && $stable(dout)));

    // R8: an accepted replay shows "nothing available" on the next cycle
    assert_rt_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && ren_n && wen_n && !busy) |=> (rd_stat_n == fwft));

    // R10: replay with an enable active does not open a setup window
    assert_rt_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_n && (!ren_n || !wen_n) && !busy) |=> !busy);
endmodule

bind fifo_dualmode fifo_dualmode_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .fwft     (mode_q),
    .busy     (q.busy),
    .wen_n    (wen_n),
    .ren_n    (ren_n),
    .rt_n     (rt_n),
    .dout     (dout),
    .rd_stat_n(rd_stat_n),
    .wr_stat_n(wr_stat_n)
);

// File: tb/sim_fifo_dualmode.sv
module sim_fifo_dualmode;
    localparam int DW     = 18;
    localparam int AW     = 4;
    localparam int DEPTH  = 1 << AW;
    localparam int RTS    = 2;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          style_i = 1'b0;
    logic          wen_n = 1'b1;
    logic          ren_n = 1'b1;
    logic          rt_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          rd_stat_n;
    logic          wr_stat_n;

    int checks = 0;
    int fails  = 0;
    int wcount = 0;
    bit fw     = 1'b0;
    bit pend   = 1'b0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] hist[$];
    logic [DW-1:0] saved;

    always #10 clk = ~clk;

    fifo_dualmode #(.DATA_W(DW), .ADDR_W(AW), .RT_SETUP(RTS), .SYNC_STAGES(2)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .style_i(style_i),
        .wen_n(wen_n), .din(din), .ren_n(ren_n), .rt_n(rt_n),
        .dout(dout), .rd_stat_n(rd_stat_n), .wr_stat_n(wr_stat_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops expected words and compares them with the output.
    task automatic monitor_step();
        logic [DW-1:0] e;
        if (!fw) begin
            if (pend) begin
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read", dout, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(dout == e, "R3 read data", dout, e);
                end
                pend = 1'b0;
            end
            if (!ren_n && rd_stat_n) pend = 1'b1;
        end else if (!rd_stat_n) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", dout, 0);
            else begin
                chk(dout == exp_q[0], "R6 presented data", dout, exp_q[0]);
                if (!ren_n) void'(exp_q.pop_front());
            end
        end
    endtask

    // Driver: applies one cycle of stimulus and records accepted writes.
    task automatic cyc(input logic w, input logic r, input logic t, input logic [DW-1:0] d);
        @(posedge clk); #2;
        wen_n = w; ren_n = r; rt_n = t; din = d;
        @(negedge clk);
        monitor_step();
        if (!wen_n && (fw ? !wr_stat_n : wr_stat_n)) begin
            exp_q.push_back(din);
            hist.push_back(din);
        end
        if (!rt_n && ren_n && wen_n) begin
            exp_q = hist;
            pend  = 1'b0;
        end
    endtask

    function automatic logic [DW-1:0] word(input int k);
        return DW'(18'h2A5 + k * 18'h1F3);
    endfunction

    task automatic wr();
        cyc(1'b0, 1'b1, 1'b1, word(wcount));
        wcount++;
    endtask
    task automatic rd();   cyc(1'b1, 1'b0, 1'b1, '0); endtask
    task automatic idle(); cyc(1'b1, 1'b1, 1'b1, '0); endtask

    task automatic drain();
        for (int i = 0; i < 4 * DEPTH; i++) begin
            if (exp_q.size() == 0 && !pend) break;
            rd();
        end
        repeat (3) idle();
    endtask

    task automatic do_mrst(input logic style);
        @(posedge clk); #2;
        style_i = style; mrst_n = 1'b0;
        wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1;
        repeat (3) @(posedge clk);
        #2 mrst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        exp_q.delete(); hist.delete(); pend = 1'b0; fw = style;
    endtask

    task automatic do_prst();
        @(posedge clk); #2;
        style_i = ~fw; prst_n = 1'b0;
        wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1;
        #1 chk(dout == '0, "R2 async clear", dout, 0);
        repeat (3) @(posedge clk);
        #2 prst_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        exp_q.delete(); hist.delete(); pend = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // ---------- standard style ----------
        do_mrst(1'b0);
        chk(rd_stat_n == 1'b0, "R1 std empty", rd_stat_n, 0);
        chk(wr_stat_n == 1'b1, "R1 std not full", wr_stat_n, 1);
        chk(dout == '0, "R1 std dout zero", dout, 0);
        style_i = 1'b1;

        wr(); idle();
        chk(rd_stat_n == 1'b1, "R3 visible after write edge", rd_stat_n, 1);
        rd(); idle();

        saved = dout;
        rd(); idle();
        chk(dout == saved, "R5 empty read keeps dout", dout, saved);
        chk(rd_stat_n == 1'b0, "R5 still empty", rd_stat_n, 0);

        wr(); wr(); cyc(1'b0, 1'b0, 1'b1, word(wcount)); wcount++;
        rd(); rd(); rd(); idle();
        chk(exp_q.size() == 0, "R3 burst drained", exp_q.size(), 0);

        for (int i = 0; i < DEPTH; i++) wr();
        idle();
        chk(wr_stat_n == 1'b0, "R4 full after DEPTH", wr_stat_n, 0);
        chk(exp_q.size() == DEPTH, "R4 accepted count", exp_q.size(), DEPTH);
        wr(); idle();
        chk(exp_q.size() == DEPTH, "R4 write while full dropped", exp_q.size(), DEPTH);
        drain();
        chk(rd_stat_n == 1'b0, "R4 empty after DEPTH reads", rd_stat_n, 0);

        // replay in standard style
        do_prst();
        chk(rd_stat_n == 1'b0 && wr_stat_n == 1'b1, "R2 std kept", {rd_stat_n, wr_stat_n}, 2'b01);
        for (int i = 0; i < 6; i++) wr();
        rd(); rd();
        cyc(1'b1, 1'b0, 1'b0, '0);
        idle();
        chk(rd_stat_n == 1'b1, "R10 replay ignored during read", rd_stat_n, 1);
        chk(exp_q.size() == 3, "R10 normal read taken", exp_q.size(), 3);
        cyc(1'b1, 1'b1, 1'b0, '0);
        for (int i = 0; i < RTS; i++) begin
            idle();
            chk(rd_stat_n == 1'b0, "R8 std setup shows empty", rd_stat_n, 0);
        end
        idle();
        chk(rd_stat_n == 1'b1, "R8 std setup complete", rd_stat_n, 1);
        chk(exp_q.size() == 6, "R8 replay length", exp_q.size(), 6);
        drain();
        chk(rd_stat_n == 1'b0 && exp_q.size() == 0, "R8 replay drained", rd_stat_n, 0);

        // ---------- fall-through style ----------
        do_mrst(1'b1);
        chk(rd_stat_n == 1'b1, "R1 fwft no data", rd_stat_n, 1);
        chk(wr_stat_n == 1'b0, "R1 fwft room", wr_stat_n, 0);
        chk(dout == '0, "R1 fwft dout zero", dout, 0);
        style_i = 1'b0;

        wr();
        saved = word(wcount - 1);
        idle(); chk(rd_stat_n == 1'b1, "R6 not after edge 1", rd_stat_n, 1);
        idle(); chk(rd_stat_n == 1'b1, "R6 not after edge 2", rd_stat_n, 1);
        idle();
        chk(rd_stat_n == 1'b0, "R6 valid after edge 3", rd_stat_n, 0);
        chk(dout == saved, "R6 first word shown", dout, saved);
        idle(); idle();
        chk(rd_stat_n == 1'b0 && dout == saved, "R6 held without read", dout, saved);
        rd(); idle();
        chk(rd_stat_n == 1'b1, "R6 empty after read", rd_stat_n, 1);

        for (int i = 0; i < 10; i++) cyc(1'b0, (i % 2 == 0), 1'b1, word(wcount + i));
        wcount += 10;
        drain();
        chk(rd_stat_n == 1'b1 && exp_q.size() == 0, "R6 stream drained", exp_q.size(), 0);

        do_prst();
        chk(rd_stat_n == 1'b1 && wr_stat_n == 1'b0, "R2 fwft kept", {rd_stat_n, wr_stat_n}, 2'b10);
        chk(dout == '0, "R2 dout zero", dout, 0);
        for (int i = 0; i < DEPTH + 2; i++) wr();
        repeat (3) idle();
        chk(wr_stat_n == 1'b1, "R7 no room", wr_stat_n, 1);
        chk(exp_q.size() == DEPTH + 2, "R7 capacity", exp_q.size(), DEPTH + 2);
        wr(); idle();
        chk(exp_q.size() == DEPTH + 2, "R7 extra write dropped", exp_q.size(), DEPTH + 2);
        drain();
        chk(rd_stat_n == 1'b1 && exp_q.size() == 0, "R7 drained", exp_q.size(), 0);

        // replay in fall-through style
        do_prst();
        for (int i = 0; i < 5; i++) wr();
        repeat (3) idle();
        rd(); rd();
        cyc(1'b1, 1'b1, 1'b0, '0);
        for (int i = 0; i < RTS + 2; i++) begin
            idle();
            chk(rd_stat_n == 1'b1, "R9 output not ready", rd_stat_n, 1);
        end
        idle();
        chk(rd_stat_n == 1'b0, "R9 ready again", rd_stat_n, 0);
        chk(dout == hist[0], "R9 first location shown", dout, hist[0]);
        drain();
        chk(rd_stat_n == 1'b1 && exp_q.size() == 0, "R8 fwft replay drained", exp_q.size(), 0);

        finish_run();
    end
endmodule